// File: doc/BRIEF.md
# Event-Matrix PWM Timer

This block is a pulse-width-modulation timer built around one shared up-counter and a bank of compare registers. Every compare register that equals the counter on a count step raises an event. Each output owns a pair of event masks. One mask lists the events that drive the output high and the other lists the events that drive it low. A separate limit mask names the events that restart the counter from zero, and this sets one period that every output shares. When an output is told to go high and low on the same step, a per-output resolution code decides the result.

Software programs the block through a word-addressed write port and a read port with one cycle of latency. A typical channel uses one compare register for the period, loaded with N-1, and one for the duty, loaded with D. It wires the period event to the output's set mask and the duty event to its clear mask, or the other way round for inverted polarity. Every compare register has a shadow reload register. The shadow value is copied in when the counter wraps, so duty and period changes take effect on a period boundary.

Top module: `evpwm_top`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0x4 (halted, prescale 0), every compare, reload, mask and resolution register reads 0, and all outputs are low.
- R2: While control bit 2 (halt) is 0, the counter steps once every (prescale+1) clock cycles, where prescale is control bits 12:5. While halt is 1 the counter holds its value.
- R3: On a count step, event n fires when compare register n equals the counter value before the step.
- R4: If a fired event is set in the limit mask (bit n for event n), the counter becomes 0 on that step. Otherwise it becomes the old value plus 1.
- R5: Output o goes high on a step where a fired event has its bit set in o's set mask, and goes low where a fired event has its bit set in o's clear mask. Outputs change only on count steps, and they change on the same clock edge as the step.
- R6: If the set and clear masks of output o both hit on one step, bits 2o+1:2o of the resolution register pick the result: 0 holds, 1 drives high, 2 drives low, 3 inverts.
- R7: On a step where the counter wraps to 0, every compare register loads its reload register. A direct write to a compare register takes precedence over the reload.
- R8: Word addresses: 0x00 control, 0x01 limit mask, 0x02 resolution, 0x03 counter (writable, reads the live value), 0x10+n compare n, 0x20+n reload n, 0x30+o set mask of output o, 0x40+o clear mask of output o. rd_data shows the register at rd_addr one cycle later. Unmapped addresses read 0.
- R9: With period event 0 (compare N-1, limit mask 1) setting the output, duty event 1 (compare D < N-1) clearing it, and code 1, the output stays high for (D+1)(prescale+1) cycles of every N(prescale+1). When D = N-1 it stays high all the time.
- R10: With the roles swapped and code 2, the output stays high for (N-1-D)(prescale+1) cycles per period. When D = N-1 it stays low all the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | 16 | Registered outputs |

## Verification
Faults in the compare, mask or resolution state change how many cycles each output spends high in a period. A steady-state window of one full period catches such a fault within a few periods of programming. A wrong prescaler, halt or limit state shows up as a wrong counter value on the read port within one period. A broken shadow transfer leaves the old value in the compare register after the first wrap. An error in the resolution codes turns a toggling output into a steady one, and a held output into a driven one, after a single period.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned HALT_BIT = 2;
  localparam int unsigned PRE_LSB  = 5;

  localparam logic [3:0] GRP_CORE   = 4'h0;
  localparam logic [3:0] GRP_MATCH  = 4'h1;
  localparam logic [3:0] GRP_RELOAD = 4'h2;
  localparam logic [3:0] GRP_SETMSK = 4'h3;
  localparam logic [3:0] GRP_CLRMSK = 4'h4;

  localparam logic [3:0] CORE_CTRL  = 4'h0;
  localparam logic [3:0] CORE_LIMIT = 4'h1;
  localparam logic [3:0] CORE_CONFL = 4'h2;
  localparam logic [3:0] CORE_COUNT = 4'h3;

  typedef enum logic [1:0] {
    RES_HOLD   = 2'd0,
    RES_HIGH   = 2'd1,
    RES_LOW    = 2'd2,
    RES_INVERT = 2'd3
  } res_code_e;
endpackage

// File: rtl/evpwm_regs.sv
module evpwm_regs
  import evpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NEV    = 16,
  parameter int unsigned NOUT   = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              reload_now,
  input  logic [CNT_W-1:0]  cnt,
  output logic              halt,
  output logic [PRE_W-1:0]  prescale,
  output logic [NEV-1:0]    limit_mask,
  output logic [2*NOUT-1:0] confl,
  output logic [CNT_W-1:0]  match_q [NEV],
  output logic [NEV-1:0]    setmsk [NOUT],
  output logic [NEV-1:0]    clrmsk [NOUT],
  output logic              cnt_load
);
  localparam int unsigned EIW = (NEV  > 1) ? $clog2(NEV)  : 1;
  localparam int unsigned OIW = (NOUT > 1) ? $clog2(NOUT) : 1;

  logic [3:0] wgrp, widx, rgrp, ridx;
  logic [CNT_W-1:0] reload_q [NEV];
  logic [DATA_W-1:0] rd_next;
  logic wr_unused;

  assign wgrp = wr_addr[7:4];
  assign widx = wr_addr[3:0];
  assign rgrp = rd_addr[7:4];
  assign ridx = rd_addr[3:0];
  assign wr_unused = ^wr_data;

  assign cnt_load = wr_en && (wgrp == GRP_CORE) && (widx == CORE_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt       <= 1'b1;
      prescale   <= '0;
      limit_mask <= '0;
      confl      <= '0;
    end else if (wr_en && wgrp == GRP_CORE) begin
      case (widx)
        CORE_CTRL: begin
          halt     <= wr_data[HALT_BIT];
          prescale <= wr_data[PRE_LSB +: PRE_W];
        end
        CORE_LIMIT: limit_mask <= wr_data[NEV-1:0];
        CORE_CONFL: confl      <= wr_data[2*NOUT-1:0];
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < NEV; n++) begin : g_ev_regs
    always_ff @(posedge clk) begin
      if (rst) begin
        match_q[n] <= '0;
      end else if (wr_en && wgrp == GRP_MATCH && widx == 4'(n)) begin
        match_q[n] <= wr_data[CNT_W-1:0];
      end else if (reload_now) begin
        match_q[n] <= reload_q[n];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        reload_q[n] <= '0;
      end else if (wr_en && wgrp == GRP_RELOAD && widx == 4'(n)) begin
        reload_q[n] <= wr_data[CNT_W-1:0];
      end
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out_regs
    always_ff @(posedge clk) begin
      if (rst) begin
        setmsk[o] <= '0;
        clrmsk[o] <= '0;
      end else if (wr_en && widx == 4'(o)) begin
        if (wgrp == GRP_SETMSK) setmsk[o] <= wr_data[NEV-1:0];
        if (wgrp == GRP_CLRMSK) clrmsk[o] <= wr_data[NEV-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (rgrp)
      GRP_CORE: begin
        case (ridx)
          CORE_CTRL: begin
            rd_next[HALT_BIT]          = halt;
            rd_next[PRE_LSB +: PRE_W]  = prescale;
          end
          CORE_LIMIT: rd_next[NEV-1:0]    = limit_mask;
          CORE_CONFL: rd_next[2*NOUT-1:0] = confl;
          CORE_COUNT: rd_next[CNT_W-1:0]  = cnt;
          default: ;
        endcase
      end
      GRP_MATCH:  if (32'(ridx) < NEV)  rd_next[CNT_W-1:0] = match_q[ridx[EIW-1:0]];
      GRP_RELOAD: if (32'(ridx) < NEV)  rd_next[CNT_W-1:0] = reload_q[ridx[EIW-1:0]];
      GRP_SETMSK: if (32'(ridx) < NOUT) rd_next[NEV-1:0]   = setmsk[ridx[OIW-1:0]];
      GRP_CLRMSK: if (32'(ridx) < NOUT) rd_next[NEV-1:0]   = clrmsk[ridx[OIW-1:0]];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/evpwm_timebase.sv
module evpwm_timebase #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [PRE_W-1:0] prescale,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             limit_hit,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [PRE_W-1:0] pre_q;

  assign tick = !halt && (pre_q >= prescale);

  always_ff @(posedge clk) begin
    if (rst || halt || tick) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (cnt_load)  cnt <= load_val;
    else if (tick)      cnt <= limit_hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/evpwm_events.sv
module evpwm_events #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NEV   = 16
) (
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] match_q [NEV],
  input  logic [NEV-1:0]   limit_mask,
  output logic [NEV-1:0]   ev,
  output logic             limit_hit
);
  for (genvar n = 0; n < NEV; n++) begin : g_cmp
    assign ev[n] = tick && (match_q[n] == cnt);
  end

  assign limit_hit = |(ev & limit_mask);
endmodule

// File: rtl/evpwm_outmatrix.sv
module evpwm_outmatrix
  import evpwm_pkg::*;
#(
  parameter int unsigned NEV  = 16,
  parameter int unsigned NOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEV-1:0]    ev,
  input  logic [NEV-1:0]    setmsk [NOUT],
  input  logic [NEV-1:0]    clrmsk [NOUT],
  input  logic [2*NOUT-1:0] confl,
  output logic [NOUT-1:0]   set_hit,
  output logic [NOUT-1:0]   clr_hit,
  output logic [NOUT-1:0]   pwm_out
);
  logic [NOUT-1:0] out_next;

  for (genvar o = 0; o < NOUT; o++) begin : g_hit
    assign set_hit[o] = |(ev & setmsk[o]);
    assign clr_hit[o] = |(ev & clrmsk[o]);
  end

  always_comb begin
    out_next = pwm_out;
    for (int o = 0; o < NOUT; o++) begin
      if (set_hit[o] && clr_hit[o]) begin
        case (res_code_e'(confl[2*o +: 2]))
          RES_HIGH:   out_next[o] = 1'b1;
          RES_LOW:    out_next[o] = 1'b0;
          RES_INVERT: out_next[o] = ~pwm_out[o];
          default:    out_next[o] = pwm_out[o];
        endcase
      end else if (set_hit[o]) begin
        out_next[o] = 1'b1;
      end else if (clr_hit[o]) begin
        out_next[o] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= '0;
    else     pwm_out <= out_next;
  end
endmodule

// File: rtl/evpwm_top.sv
module evpwm_top
  import evpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned NEV    = 16,
  parameter int unsigned NOUT   = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NOUT-1:0]   pwm_out
);
  logic              halt, tick, cnt_load, limit_hit;
  logic [PRE_W-1:0]  prescale;
  logic [NEV-1:0]    limit_mask, ev;
  logic [2*NOUT-1:0] confl;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  match_q [NEV];
  logic [NEV-1:0]    setmsk [NOUT];
  logic [NEV-1:0]    clrmsk [NOUT];
  logic [NOUT-1:0]   set_hit, clr_hit;

  evpwm_regs #(.CNT_W(CNT_W), .NEV(NEV), .NOUT(NOUT), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .reload_now(limit_hit), .cnt(cnt_q),
    .halt(halt), .prescale(prescale), .limit_mask(limit_mask), .confl(confl),
    .match_q(match_q), .setmsk(setmsk), .clrmsk(clrmsk), .cnt_load(cnt_load)
  );

  evpwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_time (
    .clk(clk), .rst(rst), .halt(halt), .prescale(prescale), .cnt_load(cnt_load),
    .load_val(wr_data[CNT_W-1:0]), .limit_hit(limit_hit), .tick(tick), .cnt(cnt_q)
  );

  evpwm_events #(.CNT_W(CNT_W), .NEV(NEV)) u_events (
    .tick(tick), .cnt(cnt_q), .match_q(match_q), .limit_mask(limit_mask),
    .ev(ev), .limit_hit(limit_hit)
  );

  evpwm_outmatrix #(.NEV(NEV), .NOUT(NOUT)) u_outs (
    .clk(clk), .rst(rst), .ev(ev), .setmsk(setmsk), .clrmsk(clrmsk), .confl(confl),
    .set_hit(set_hit), .clr_hit(clr_hit), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/evpwm_checker.sv
module evpwm_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NOUT  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              halt,
  input logic              cnt_load,
  input logic              limit_hit,
  input logic [CNT_W-1:0]  cnt,
  input logic [NOUT-1:0]   pwm_out,
  input logic [NOUT-1:0]   set_hit,
  input logic [NOUT-1:0]   clr_hit,
  input logic [2*NOUT-1:0] confl
);
  assert_halt_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (halt && !cnt_load) |=> $stable(cnt));

  assert_step_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !limit_hit && !cnt_load) |=> (cnt == $past(cnt) + 1'b1));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && limit_hit && !cnt_load) |=> (cnt == '0));

  assert_out_only_on_step_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pwm_out));

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    assert_set_wins_alone_R5: assert property (@(posedge clk) disable iff (rst)
      (set_hit[o] && !clr_hit[o]) |=> pwm_out[o]);
    assert_hold_code_R6: assert property (@(posedge clk) disable iff (rst)
      (set_hit[o] && clr_hit[o] && confl[2*o +: 2] == 2'd0) |=> $stable(pwm_out[o]));
    assert_invert_code_R6: assert property (@(posedge clk) disable iff (rst)
      (set_hit[o] && clr_hit[o] && confl[2*o +: 2] == 2'd3) |=> (pwm_out[o] != $past(pwm_out[o])));
  end
endmodule

bind evpwm_top evpwm_checker #(.CNT_W(CNT_W), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .halt(halt), .cnt_load(cnt_load),
  .limit_hit(limit_hit), .cnt(cnt_q), .pwm_out(pwm_out), .set_hit(set_hit),
  .clr_hit(clr_hit), .confl(confl)
);

// File: tb/evpwm_top_bench.sv
module evpwm_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] pwm_out;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evpwm_top u_evpwm_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  // {prescale, period N, duty D, inverted}
  localparam logic [31:0] VEC [7] = '{
    32'h00_0A_03_00, 32'h00_0A_03_01, 32'h02_08_00_00, 32'h01_06_05_00,
    32'h01_06_05_01, 32'h00_10_07_01, 32'h03_05_02_00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic int exp_high(int pre, int n, int d, bit inv);
    if (d >= n - 1) return inv ? 0 : n * (pre + 1);
    return inv ? (n - 1 - d) * (pre + 1) : (d + 1) * (pre + 1);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {16'h0, pwm_out}, 32'h0);
    rd(8'h00, v); chk("R1 control", v, 32'h4);
    rd(8'h03, v); chk("R1 counter", v, 32'h0);
    rd(8'h02, v); chk("R1 resolution", v, 32'h0);
    rd(8'h15, v); chk("R1 compare5", v, 32'h0);

    // R3 R5 R9 R10 table of PWM configurations
    for (int i = 0; i < 7; i++) begin
      int pre, n, d, hi;
      bit inv;
      pre = int'(VEC[i][31:24]); n = int'(VEC[i][23:16]);
      d = int'(VEC[i][15:8]); inv = VEC[i][0];
      wr(8'h00, 32'h4);
      wr(8'h03, 32'h0);
      wr(8'h10, 32'(n - 1)); wr(8'h20, 32'(n - 1));
      wr(8'h11, 32'(d));     wr(8'h21, 32'(d));
      wr(8'h01, 32'h1);
      wr(8'h30, inv ? 32'h2 : 32'h1);
      wr(8'h40, inv ? 32'h1 : 32'h2);
      wr(8'h02, inv ? 32'h2 : 32'h1);
      wr(8'h00, 32'(pre) << 5);
      repeat (3 * n * (pre + 1) + 5) @(negedge clk);
      hi = 0;
      for (int c = 0; c < n * (pre + 1); c++) begin
        if (pwm_out[0]) hi++;
        @(negedge clk);
      end
      chk(inv ? "R10 R3 R5 inverted high cycles" : "R9 R3 R5 normal high cycles",
          32'(hi), 32'(exp_high(pre, n, d, inv)));
    end

    // R2 halt freezes the counter
    wr(8'h00, 32'h4);
    rd(8'h03, a);
    repeat (5) @(negedge clk);
    rd(8'h03, b);
    chk("R2 halt", b, a);

    // R2 prescale 3: 40 clock edges give 10 steps; limit mask 0 means no wrap (R4)
    wr(8'h01, 32'h0);
    wr(8'h03, 32'h0);
    wr(8'h00, 32'h3 << 5);
    repeat (4) @(negedge clk);
    rd(8'h03, a);
    repeat (39) @(negedge clk);
    rd(8'h03, b);
    chk("R2 prescale steps", b - a, 32'd10);

    // R7 R8 reload takes effect only at the wrap
    wr(8'h00, 32'h4);
    wr(8'h03, 32'h0);
    wr(8'h10, 32'd9); wr(8'h20, 32'd9);
    wr(8'h11, 32'd3); wr(8'h21, 32'd6);
    wr(8'h01, 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h11, v); chk("R7 compare before wrap", v, 32'd3);
    repeat (15) @(negedge clk);
    rd(8'h11, v); chk("R7 compare after wrap", v, 32'd6);

    // R4 counter stays within the period
    b = 0;
    for (int k = 0; k < 12; k++) begin
      rd(8'h03, v);
      if (v > b) b = v;
    end
    chk("R4 counter max", b, 32'd9);

    // R6 code 3 inverts output 3, code 0 holds output 2
    wr(8'h00, 32'h4);
    wr(8'h03, 32'h0);
    wr(8'h10, 32'd5); wr(8'h20, 32'd5);
    wr(8'h33, 32'h1); wr(8'h43, 32'h1);
    wr(8'h32, 32'h1); wr(8'h42, 32'h1);
    wr(8'h02, (32'd3 << 6) | (32'd0 << 4));
    wr(8'h00, 32'h0);
    repeat (20) @(negedge clk);
    a = {31'h0, pwm_out[3]};
    repeat (6) @(negedge clk);
    b = {31'h0, pwm_out[3]};
    chk("R6 invert code", b, a ^ 32'h1);
    chk("R6 hold code", {31'h0, pwm_out[2]}, 32'h0);

    done = 1;
    summary();
  end
endmodule